// File: doc/BRIEF.md
# Module Clock and Reset State Controller

This block sequences the clock enable and the reset of a group of peripheral modules through a small set of power states. Software writes a requested state into each module's control register; nothing moves until a single go command is written to the domain command register, after which every module whose request differs from its current state walks towards it one state at a time, spending a fixed number of cycles in each step. A busy bit stays high until all modules have arrived, and go commands written while it is high are dropped.

Independently of the state machines, each module has a local-reset control that is passed to a separate output one cycle after it is written. Two emulation event inputs per module (an emulation-reset request and an emulation-inhibit request) can each be enabled to raise one shared interrupt line. One module, chosen by parameter, is the only one that supports emulation control; any event on it sets a sticky error-pending bit that software clears by writing 1.

The register port is a plain single-cycle write strobe with a combinational read. The single power domain is always on, so no supply switching is modelled.

Top module: `modclk_ctrl`

## Requirements
- R1: After reset every module is in state 0 (clock enable 0, module reset asserted low), every local-reset output is 1, the interrupt is 0, the busy bit is 0 and the error-pending register reads 0.
- R2: The control register of module i sits at byte address 0x40+4*i: bits 2:0 requested state, bit 8 local-reset control (reset value 1), bit 9 emulation-reset interrupt enable, bit 10 emulation-inhibit interrupt enable; it reads back what was written in those bits and 0 elsewhere.
- R3: A write to the requested-state field does not change any module output; the request takes effect only after a write of 1 to bit 0 of the command register at address 0x00, and that register always reads 0.
- R4: State codes drive the outputs as follows: 0 clock off and reset asserted, 1 clock on and reset asserted, 2 clock off and reset released, 3 clock on and reset released.
- R5: After a go command accepted at clock edge E, a module moving up or down changes state by exactly one code at edges E+STEP, E+2*STEP, and so on, passing every intermediate code in order, until it reaches its request.
- R6: A module's reset output rises only in a cycle that follows one in which its clock enable was 1.
- R7: Bit 0 of the status register at address 0x04 is 1 while any module differs from its accepted request and clears at the edge on which the last one arrives; a go command written while it is 1 is ignored.
- R8: In state 2 the module clock is off while reset stays released, so a module parked in state 2 keeps its reset output at 1.
- R9: The local-reset output of module i takes the value of control bit 8 one clock edge after the write, independently of the module's state; writing 0 asserts it.
- R10: The status register of module i at address 0x80+4*i reports the state code in bits 5:0, the local-reset output in bit 8, bit 9 = 1 when that output matches control bit 8, the module-reset output in bit 10, the clock enable in bit 12, and the raw emulation-reset and emulation-inhibit inputs in bits 16 and 17.
- R11: The interrupt output is 1 exactly while at least one module has an emulation event input high whose enable bit is set.
- R12: The error-pending register at address 0x08 has one bit, at the position of the emulation-capable module, set one edge after either of that module's event inputs is high and cleared by writing 1 to it; events of other modules never set it.
- R13: A requested-state value of 4 to 7 leaves that module's accepted request unchanged when go is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| emu_rst_evt | input | NMOD | Emulation-reset event per module |
| emu_inh_evt | input | NMOD | Emulation-inhibit event per module |
| mod_clk_en | output | NMOD | Module clock enable |
| mod_rst_n | output | NMOD | Module reset, active low |
| mod_lrst_n | output | NMOD | Local reset, active low |
| irq | output | 1 | Combined emulation-event interrupt |

## Verification
A go command is accepted at the edge that samples the write, and each state step then lands exactly STEP edges later, so the bench samples one negative edge before and one after each expected step to catch both early and late movement. Register writes land at their own edge and are visible on reads right after it, local-reset outputs follow one edge later, and the interrupt follows the event inputs and enables in the same cycle; every check samples at the falling edge in the cycle its value is due. The busy bit is checked both right after a go and right after the final step.

// File: rtl/modclk_ctrl.sv
module modclk_ctrl #(
  parameter int NMOD    = 4,
  parameter int STEP    = 4,
  parameter int EMU_MOD = NMOD - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NMOD-1:0] emu_rst_evt,
  input  logic [NMOD-1:0] emu_inh_evt,
  output logic [NMOD-1:0] mod_clk_en,
  output logic [NMOD-1:0] mod_rst_n,
  output logic [NMOD-1:0] mod_lrst_n,
  output logic            irq
);
  localparam int CW = $clog2(STEP + 1);

  logic [NMOD-1:0][1:0]    cur, tgt;
  logic [NMOD-1:0][2:0]    nxt;
  logic [NMOD-1:0][CW-1:0] cnt;
  logic [NMOD-1:0]         lrst_c, lrst_q, ie_rst, ie_inh, mov;
  logic                    err_q;

  wire       ctl_sel = bus_addr[7:6] == 2'b01;
  wire       sts_sel = bus_addr[7:6] == 2'b10;
  wire [3:0] idx     = bus_addr[5:2];
  wire       go_wr   = bus_wr && bus_addr == 8'h00 && bus_wdata[0];
  wire       busy    = |mov;
  wire       go_ok   = go_wr && !busy;
  wire       err_set = emu_rst_evt[EMU_MOD] | emu_inh_evt[EMU_MOD];
  wire       err_clr = bus_wr && bus_addr == 8'h08 && bus_wdata[EMU_MOD];

  always_comb
    for (int i = 0; i < NMOD; i++) mov[i] = cur[i] != tgt[i];

  assign irq        = |((emu_rst_evt & ie_rst) | (emu_inh_evt & ie_inh));
  assign mod_lrst_n = lrst_q;
  always_comb
    for (int i = 0; i < NMOD; i++) begin
      mod_clk_en[i] = cur[i][0];
      mod_rst_n[i]  = cur[i][1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur    <= '0;
      tgt    <= '0;
      nxt    <= '0;
      cnt    <= '0;
      lrst_c <= '1;
      lrst_q <= '1;
      ie_rst <= '0;
      ie_inh <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q  <= (err_q & ~err_clr) | err_set;
      lrst_q <= lrst_c;
      for (int i = 0; i < NMOD; i++) begin
        if (bus_wr && ctl_sel && idx == 4'(i)) begin
          nxt[i]    <= bus_wdata[2:0];
          lrst_c[i] <= bus_wdata[8];
          ie_rst[i] <= bus_wdata[9];
          ie_inh[i] <= bus_wdata[10];
        end
        if (go_ok && nxt[i] <= 3'd3) tgt[i] <= nxt[i][1:0];
        if (mov[i]) begin
          if (cnt[i] == CW'(STEP - 1)) begin
            cnt[i] <= '0;
            cur[i] <= (tgt[i] > cur[i]) ? cur[i] + 2'd1 : cur[i] - 2'd1;
          end else begin
            cnt[i] <= cnt[i] + 1'b1;
          end
        end
      end
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 8'h04) bus_rdata[0] = busy;
    if (bus_addr == 8'h08) bus_rdata[EMU_MOD] = err_q;
    for (int i = 0; i < NMOD; i++) begin
      if (ctl_sel && idx == 4'(i))
        bus_rdata = {21'b0, ie_inh[i], ie_rst[i], lrst_c[i], 5'b0, nxt[i]};
      if (sts_sel && idx == 4'(i))
        bus_rdata = {14'b0, emu_inh_evt[i], emu_rst_evt[i], 3'b0, cur[i][0], 1'b0,
                     cur[i][1], lrst_q[i] == lrst_c[i], lrst_q[i], 6'b0, cur[i]};
    end
  end

  assert_go_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> $stable(tgt));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur));

  for (genvar g = 0; g < NMOD; g++) begin : g_chk
    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur[g] != $past(cur[g])) |->
        (cur[g] == $past(cur[g]) + 2'd1 || cur[g] == $past(cur[g]) - 2'd1));

    assert_clock_before_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_rst_n[g]) |-> $past(mod_clk_en[g]));
  end
endmodule

// File: tb/tb_modclk_ctrl.sv
module tb_modclk_ctrl;
  localparam int NMOD = 4;
  localparam int STEP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NMOD-1:0] emu_rst_evt = '0, emu_inh_evt = '0;
  logic [NMOD-1:0] mod_clk_en, mod_rst_n, mod_lrst_n;
  logic            irq;

  int vectors = 0;
  int miscompares = 0;

  modclk_ctrl #(.NMOD(NMOD), .STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .emu_rst_evt(emu_rst_evt),
    .emu_inh_evt(emu_inh_evt), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n),
    .mod_lrst_n(mod_lrst_n), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] outs(input int m);
    return {mod_rst_n[m], mod_clk_en[m]};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    check("R1 clk_en", 32'(mod_clk_en), 0);
    check("R1 rst_n", 32'(mod_rst_n), 0);
    check("R1 lrst_n", 32'(mod_lrst_n), 32'hF);
    check("R1 irq", 32'(irq), 0);
    rd(8'h04, v); check("R1 busy", v, 0);
    rd(8'h08, v); check("R1 err", v, 0);
  endtask

  task automatic t_up;
    logic [31:0] v;
    wr(8'h40, 32'h103);
    wait_n(2);
    check("R3 no effect before go", 32'(outs(0)), 0);
    rd(8'h40, v); check("R2 ctrl readback", v, 32'h103);
    wr(8'h00, 1);
    rd(8'h00, v); check("R3 cmd reads 0", v, 0);
    rd(8'h04, v); check("R7 busy after go", v, 1);
    wait_n(STEP - 1); check("R5 step1 not early", 32'(outs(0)), 0);
    wait_n(1);        check("R4 R5 state1", 32'(outs(0)), 32'b01);
    wait_n(STEP - 1); check("R5 step2 not early", 32'(outs(0)), 32'b01);
    wait_n(1);        check("R8 state2 clk off rst released", 32'(outs(0)), 32'b10);
    rd(8'h04, v); check("R7 busy mid", v, 1);
    wait_n(STEP);     check("R4 state3", 32'(outs(0)), 32'b11);
    rd(8'h04, v); check("R7 busy cleared", v, 0);
    rd(8'h80, v); check("R10 status mod0", v, 32'h1703);
  endtask

  task automatic t_go_busy;
    logic [31:0] v;
    wr(8'h44, 32'h102);
    wr(8'h00, 1);
    wr(8'h48, 32'h101);
    wr(8'h00, 1);
    wait_n(2 * STEP + 4);
    check("R7 ignored go mod2", 32'(outs(2)), 0);
    check("R8 mod1 parked in 2", 32'(outs(1)), 32'b10);
    rd(8'h84, v); check("R10 status mod1", v, 32'h702);
    rd(8'h88, v); check("R10 status mod2", v, 32'h300);
    rd(8'h04, v); check("R7 idle", v, 0);
    wr(8'h48, 32'h100);
  endtask

  task automatic t_down;
    wr(8'h40, 32'h100);
    wr(8'h00, 1);
    wait_n(STEP - 1); check("R5 down hold", 32'(outs(0)), 32'b11);
    wait_n(1);        check("R5 down to 2", 32'(outs(0)), 32'b10);
    wait_n(STEP);     check("R5 down to 1", 32'(outs(0)), 32'b01);
    wait_n(STEP);     check("R5 down to 0", 32'(outs(0)), 0);
  endtask

  task automatic t_bad_code;
    logic [31:0] v;
    wr(8'h4C, 32'h105);
    wr(8'h40, 32'h107);
    wr(8'h00, 1);
    rd(8'h04, v); check("R13 no busy", v, 0);
    wait_n(3 * STEP);
    check("R13 mod3 unchanged", 32'(outs(3)), 0);
    check("R13 mod0 unchanged", 32'(outs(0)), 0);
  endtask

  task automatic t_lrst;
    logic [31:0] v;
    wr(8'h40, 32'h000);
    check("R9 lrst not yet", 32'(mod_lrst_n[0]), 1);
    rd(8'h80, v); check("R10 lrst pending", v, 32'h100);
    wait_n(1);
    check("R9 lrst asserted", 32'(mod_lrst_n[0]), 0);
    rd(8'h80, v); check("R10 lrst done", v, 32'h200);
    check("R9 state untouched", 32'(outs(0)), 0);
    check("R9 mod1 state untouched", 32'(outs(1)), 32'b10);
    wr(8'h40, 32'h100);
    wait_n(1);
    check("R9 lrst released", 32'(mod_lrst_n[0]), 1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    @(negedge clk); emu_rst_evt[1] = 1'b1;
    #0.5; check("R11 disabled event", 32'(irq), 0);
    wr(8'h44, 32'h302);
    check("R11 enabled event", 32'(irq), 1);
    rd(8'h84, v); check("R10 event bit", v, 32'h10702);
    rd(8'h08, v); check("R12 other module no error", v, 0);
    emu_rst_evt[1] = 1'b0;
    #0.5; check("R11 event gone", 32'(irq), 0);
    wr(8'h48, 32'h500);
    emu_inh_evt[2] = 1'b1;
    #0.5; check("R11 inhibit event", 32'(irq), 1);
    @(negedge clk); emu_inh_evt[2] = 1'b0;
    #0.5; check("R11 inhibit gone", 32'(irq), 0);
  endtask

  task automatic t_err;
    logic [31:0] v;
    @(negedge clk); emu_inh_evt[3] = 1'b1;
    @(negedge clk); emu_inh_evt[3] = 1'b0;
    rd(8'h08, v); check("R12 error set", v, 32'h8);
    wait_n(2);
    rd(8'h08, v); check("R12 error sticky", v, 32'h8);
    wr(8'h08, 32'h8);
    rd(8'h08, v); check("R12 error cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_up();
    t_go_busy();
    t_down();
    t_bad_code();
    t_lrst();
    t_irq();
    t_err();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule